// File: doc/BRIEF.md
# Paged EEPROM Burst Writer with Completion Polling

This block is a bus master that stores a burst of bytes into a byte-wide parallel EEPROM. A user supplies a start address, a length and a stream of bytes over valid/ready handshakes. The block drives the memory's address, data and active-low select, read-enable and write-enable lines. It issues one write strobe per byte and cuts the burst wherever it reaches the end of a 64-byte page.

After the last byte it loads into a page, the block stops writing. It reads back the last written address until the memory reports that its internal programming cycle has finished. Two detection methods are available, chosen per request. In the first, bit 7 of the read-back must match bit 7 of the byte that was written. In the second, bit 6 must return the same value on two reads in a row. Only then does the burst go on into the next page.

When the final page finishes, a one-cycle done pulse is raised. If any page is still not finished after a programmable number of cycles, the block gives up, sets an error flag and returns to idle. The error flag stays set until the next request is accepted.

Top module: `eeprom_burst_writer`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_drive` is low, `busy`, `done` and `timeout_err` are low, `req_ready` is high.
- R2: Each byte is written by holding `mem_we_n` low for exactly WE_CYC cycles. During that pulse `mem_ce_n` is low, `mem_oe_n` is high and `mem_drive` is high. Address and data are stable from the first low cycle until one cycle after `mem_we_n` rises.
- R3: `mem_drive` is never high while `mem_oe_n` is low.
- R4: The write strobes between two polling phases all share address bits [ADDR_W-1:PAGE_W], the page number. No strobe for a new page occurs until the previous page's poll has reported completion.
- R5: With `req_toggle`=0, a page is complete when bit 7 of a read equals bit 7 of the last byte written to that page. Every poll read uses the address of the last written byte.
- R6: With `req_toggle`=1, a page is complete when two consecutive poll reads return the same bit 6. A single read never completes a page.
- R7: Each read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for at least ACC_CYC cycles, with the address stable, before the data is taken.
- R8: If a page is not complete TIMEOUT_CYC cycles after its poll starts, `timeout_err` goes high, no done pulse is given and the block returns to idle. Accepting the next request clears `timeout_err`.
- R9: `done` is high for exactly one cycle after the final page completes without error, and `busy` is low in that cycle.
- R10: A request with `req_len`=L writes L+1 bytes. It takes them in the order they arrive on the write handshake and stores them at consecutive addresses starting at `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid is also high |
| req_addr | input | ADDR_W | First byte address |
| req_len | input | ADDR_W | Byte count minus one |
| req_toggle | input | 1 | 1 selects bit-6 stability polling, 0 selects bit-7 match polling |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Block takes a byte when valid is also high |
| wr_data | input | 8 | Write byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | 8 | Data toward the memory |
| mem_drive | output | 1 | Enable for the data bus driver toward the memory |
| mem_din | input | 8 | Data read from the memory |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle success pulse |
| timeout_err | output | 1 | Poll gave up; held until the next request |

## Verification
The hardest case to reach is a request that spans a page boundary, because that is the only place where a write strobe could illegally follow a poll read while the memory is still busy. The bench memory model stays busy for a fixed number of cycles after each strobe and marks itself once it has been read while busy. Any strobe in that state is counted as a violation. Requests starting four bytes and two bytes before a boundary drive the block through this case in both polling methods. A second hard case is a memory that never completes; the model can freeze its busy state to force a timeout and then release it so that recovery can be checked.

// File: rtl/ewp_pkg.sv
package ewp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SETUP,
    S_STROBE,
    S_HOLD,
    S_READ,
    S_GAP
  } ewp_state_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/ewp_down_timer.sv
module ewp_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ewp_page_tracker.sv
module ewp_page_tracker #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [ADDR_W-1:0] load_len,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_byte,
  output logic              page_end
);
  logic [ADDR_W:0] remaining;

  function automatic logic at_page_end(input logic [ADDR_W-1:0] a);
    return a[PAGE_W-1:0] == {PAGE_W{1'b1}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remaining <= '0;
    end else if (load) begin
      cur_addr  <= load_addr;
      remaining <= {1'b0, load_len} + {{ADDR_W{1'b0}}, 1'b1};
    end else if (advance) begin
      cur_addr  <= cur_addr + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end

  assign last_byte = (remaining == {{ADDR_W{1'b0}}, 1'b1});
  assign page_end  = at_page_end(cur_addr);
endmodule

// File: rtl/ewp_poll_judge.sv
module ewp_poll_judge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       sample,
  input  logic       toggle_mode,
  input  logic       ref_bit7,
  input  logic [1:0] rd_hi,
  output logic       pass
);
  logic have_prev;
  logic prev_b6;
  logic verdict;

  always_comb begin
    if (toggle_mode) verdict = have_prev && (rd_hi[0] == prev_b6);
    else             verdict = (rd_hi[1] == ref_bit7);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_b6   <= 1'b0;
      pass      <= 1'b0;
    end else if (arm) begin
      have_prev <= 1'b0;
      pass      <= 1'b0;
    end else if (sample) begin
      have_prev <= 1'b1;
      prev_b6   <= rd_hi[0];
      pass      <= verdict;
    end
  end
endmodule

// File: rtl/eeprom_burst_writer.sv
module eeprom_burst_writer
  import ewp_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 6,
  parameter int SETUP_CYC   = 2,
  parameter int WE_CYC      = 10,
  parameter int ACC_CYC     = 20,
  parameter int TIMEOUT_CYC = 1200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  input  logic              req_toggle,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dout,
  output logic              mem_drive,
  input  logic [7:0]        mem_din,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);
  localparam int unsigned PH_MAX = max3(SETUP_CYC, WE_CYC, ACC_CYC);
  localparam int PH_W = bits_for(PH_MAX);
  localparam int WD_W = bits_for(TIMEOUT_CYC);
  localparam logic [PH_W-1:0] PH_SETUP = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0] PH_WE    = PH_W'(WE_CYC - 1);
  localparam logic [PH_W-1:0] PH_ACC   = PH_W'(ACC_CYC - 1);
  localparam logic [WD_W-1:0] WD_LIMIT = WD_W'(TIMEOUT_CYC);

  ewp_state_t state, state_nx;
  logic [7:0] data_q;
  logic       mode_q;
  logic       done_q;
  logic       err_q;

  logic            ph_load;
  logic [PH_W-1:0] ph_val;
  logic            ph_exp;
  logic            wd_exp;
  logic            trk_load, trk_adv;
  logic            trk_last, trk_pend;
  logic            jd_pass;

  // named internal events
  logic req_take, byte_take, strobe_start, poll_start, poll_sample, poll_pass, wd_trip;

  ewp_down_timer #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_exp)
  );

  ewp_down_timer #(.W(WD_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .load(poll_start), .load_val(WD_LIMIT), .expired(wd_exp)
  );

  ewp_page_tracker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .load(trk_load), .load_addr(req_addr), .load_len(req_len),
    .advance(trk_adv), .cur_addr(mem_addr), .last_byte(trk_last), .page_end(trk_pend)
  );

  ewp_poll_judge u_judge (
    .clk(clk), .rst_n(rst_n), .arm(poll_start), .sample(poll_sample),
    .toggle_mode(mode_q), .ref_bit7(data_q[7]), .rd_hi(mem_din[7:6]), .pass(jd_pass)
  );

  assign req_ready    = (state == S_IDLE);
  assign wr_ready     = (state == S_LOAD);
  assign req_take     = req_ready && req_valid;
  assign byte_take    = wr_ready && wr_valid;
  assign strobe_start = (state == S_SETUP) && ph_exp;
  assign poll_start   = (state == S_HOLD) && (trk_pend || trk_last);
  assign poll_sample  = (state == S_READ) && ph_exp;
  assign poll_pass    = (state == S_GAP) && jd_pass;
  assign wd_trip      = (state == S_GAP) && !jd_pass && wd_exp;

  always_comb begin
    state_nx = state;
    ph_load  = 1'b0;
    ph_val   = PH_SETUP;
    trk_load = 1'b0;
    trk_adv  = 1'b0;
    unique case (state)
      S_IDLE: if (req_take) begin
        trk_load = 1'b1;
        state_nx = S_LOAD;
      end
      S_LOAD: if (byte_take) begin
        ph_load  = 1'b1;
        ph_val   = PH_SETUP;
        state_nx = S_SETUP;
      end
      S_SETUP: if (ph_exp) begin
        ph_load  = 1'b1;
        ph_val   = PH_WE;
        state_nx = S_STROBE;
      end
      S_STROBE: if (ph_exp) state_nx = S_HOLD;
      S_HOLD: begin
        if (poll_start) begin
          ph_load  = 1'b1;
          ph_val   = PH_ACC;
          state_nx = S_READ;
        end else begin
          trk_adv  = 1'b1;
          state_nx = S_LOAD;
        end
      end
      S_READ: if (ph_exp) state_nx = S_GAP;
      S_GAP: begin
        if (poll_pass) begin
          if (trk_last) state_nx = S_IDLE;
          else begin
            trk_adv  = 1'b1;
            state_nx = S_LOAD;
          end
        end else if (wd_exp) begin
          state_nx = S_IDLE;
        end else begin
          ph_load  = 1'b1;
          ph_val   = PH_ACC;
          state_nx = S_READ;
        end
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      data_q <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= poll_pass && trk_last;
      if (req_take) begin
        mode_q <= req_toggle;
        err_q  <= 1'b0;
      end
      if (byte_take) data_q <= wr_data;
      if (wd_trip)   err_q  <= 1'b1;
    end
  end

  assign mem_drive   = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
  assign mem_dout    = data_q;
  assign mem_ce_n    = !(mem_drive || (state == S_READ));
  assign mem_oe_n    = (state != S_READ);
  assign mem_we_n    = (state != S_STROBE);
  assign busy        = (state != S_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;
endmodule

// File: rtl/ewp_checker.sv
module ewp_checker #(
  parameter int ADDR_W  = 13,
  parameter int PAGE_W  = 6,
  parameter int WE_CYC  = 10,
  parameter int ACC_CYC = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_dout,
  input logic              mem_drive,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              busy,
  input logic              done,
  input logic              timeout_err,
  input logic              strobe_start,
  input logic              poll_start
);
  p_drive_oe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drive |-> mem_oe_n);

  p_strobe_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_drive));

  p_strobe_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

  p_strobe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dout) && !mem_ce_n));

  p_read_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  p_read_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !$past(mem_oe_n)) |-> $stable(mem_addr));

  p_poll_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_start |=> !mem_oe_n);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !timeout_err));

  int  oe_cnt;
  int  we_cnt;
  logic pg_open;
  logic [ADDR_W-PAGE_W-1:0] pg_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_cnt  <= 0;
      we_cnt  <= 0;
      pg_open <= 1'b0;
      pg_tag  <= '0;
    end else begin
      if (!mem_oe_n) oe_cnt <= oe_cnt + 1;
      else begin
        if (oe_cnt != 0) p_read_len_r7: assert (oe_cnt >= ACC_CYC);
        oe_cnt <= 0;
      end
      if (!mem_we_n) we_cnt <= we_cnt + 1;
      else begin
        if (we_cnt != 0) p_we_width_r2: assert (we_cnt == WE_CYC);
        we_cnt <= 0;
      end
      if (!mem_oe_n) pg_open <= 1'b0;
      else if (strobe_start) begin
        if (pg_open) p_one_page_r4: assert (mem_addr[ADDR_W-1:PAGE_W] == pg_tag);
        pg_open <= 1'b1;
        pg_tag  <= mem_addr[ADDR_W-1:PAGE_W];
      end
    end
  end
endmodule

bind eeprom_burst_writer ewp_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WE_CYC(WE_CYC), .ACC_CYC(ACC_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
  .mem_drive(mem_drive), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .busy(busy), .done(done), .timeout_err(timeout_err),
  .strobe_start(strobe_start), .poll_start(poll_start)
);

// File: tb/eeprom_burst_writer_test.sv
module eeprom_burst_writer_test;
  localparam int AW = 13;
  localparam int PW = 6;
  localparam int SET_C = 2;
  localparam int WE_C = 3;
  localparam int ACC_C = 3;
  localparam int TO_C = 400;
  localparam int PROG_C = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_toggle = 1'b0, wr_valid = 1'b0;
  logic [AW-1:0] req_addr = '0, req_len = '0;
  logic [7:0] wr_data = '0;
  logic req_ready, wr_ready, mem_drive, mem_ce_n, mem_oe_n, mem_we_n, busy, done, timeout_err;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_dout, mem_din;

  always #5 clk = ~clk;

  eeprom_burst_writer #(.ADDR_W(AW), .PAGE_W(PW), .SETUP_CYC(SET_C), .WE_CYC(WE_C),
                        .ACC_CYC(ACC_C), .TIMEOUT_CYC(TO_C)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_toggle(req_toggle),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_drive(mem_drive), .mem_din(mem_din),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .busy(busy), .done(done), .timeout_err(timeout_err)
  );

  // ---------------- memory model and monitor ----------------
  logic [7:0] mem_arr [0:1023];
  logic m_busy = 1'b0, m_polled = 1'b0, m_tog = 1'b0, m_stuck = 1'b0;
  int   m_cnt = 0;
  logic [7:0] m_last_d = '0;
  logic [AW-1:0] m_last_a = '0;
  logic [AW-PW-1:0] m_page = '0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [7:0] we_d = '0;
  logic [AW-1:0] we_a = '0;
  int we_low = 0, oe_low = 0;
  int n_strobe, n_reads, n_busy_reads, n_done;
  int v_wewidth, v_wectl, v_westable, v_early, v_page, v_rdaddr, v_rdshort, v_contend, v_done_busy;
  int clr_req = 0, clr_seen = 0;

  assign mem_din = m_busy ? {~m_last_d[7], m_tog, m_last_d[5:0]} : mem_arr[mem_addr[9:0]];

  initial begin
    for (int i = 0; i < 1024; i++) mem_arr[i] = 8'hFF;
  end

  always @(negedge clk) begin
    if (clr_req != clr_seen) begin
      clr_seen = clr_req;
      n_strobe = 0; n_reads = 0; n_busy_reads = 0; n_done = 0;
      v_wewidth = 0; v_wectl = 0; v_westable = 0; v_early = 0; v_page = 0;
      v_rdaddr = 0; v_rdshort = 0; v_contend = 0; v_done_busy = 0;
    end
    if (rst_n) begin
      if (!mem_we_n) begin
        if (prev_we) begin we_d = mem_dout; we_a = mem_addr; end
        we_low++;
      end else if (!prev_we) begin
        if (we_low != WE_C) v_wewidth++;
        if (mem_ce_n || !mem_oe_n) v_wectl++;
        if (mem_dout != we_d || mem_addr != we_a) v_westable++;
        mem_arr[mem_addr[9:0]] = mem_dout;
        if (m_busy && m_polled) v_early++;
        if (m_busy && mem_addr[AW-1:PW] != m_page) v_page++;
        if (!m_busy) m_page = mem_addr[AW-1:PW];
        m_busy = 1'b1; m_cnt = PROG_C;
        m_last_d = mem_dout; m_last_a = mem_addr;
        n_strobe++;
        we_low = 0;
      end
      if (!mem_oe_n) begin
        if (prev_oe) begin
          n_reads++;
          if (mem_addr != m_last_a) v_rdaddr++;
          if (m_busy) begin m_polled = 1'b1; m_tog = ~m_tog; n_busy_reads++; end
        end
        oe_low++;
      end else if (!prev_oe) begin
        if (oe_low < ACC_C) v_rdshort++;
        oe_low = 0;
      end
      if (mem_drive && !mem_oe_n) v_contend++;
      if (done) begin n_done++; if (m_busy) v_done_busy++; end
      if (m_busy && !m_stuck) begin
        if (m_cnt == 0) begin m_busy = 1'b0; m_polled = 1'b0; end
        else m_cnt--;
      end
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
    end
  end

  // ---------------- checking helpers ----------------
  int errors = 0, checks = 0;
  logic [7:0] pat [0:63];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    clr_req++;
    @(negedge clk);
  endtask

  task automatic run_req(input logic [AW-1:0] a, input int n, input logic tmode,
                         output int cyc, output bit got_done, output bit got_err);
    int fed = 0;
    bit rq_pend = 0, wr_pend = 0;
    got_done = 0; got_err = 0; cyc = 0;
    @(negedge clk);
    req_addr = a; req_len = AW'(n - 1); req_toggle = tmode; req_valid = 1'b1;
    for (int c = 0; c < 5000; c++) begin
      if (rq_pend) req_valid = 1'b0;
      if (wr_pend) fed++;
      wr_valid = (fed < n);
      wr_data  = (fed < n) ? pat[fed] : 8'h00;
      rq_pend  = req_valid && req_ready;
      wr_pend  = wr_valid && wr_ready;
      if (done) got_done = 1;
      if (timeout_err && !req_valid) got_err = 1;
      if (got_done || got_err) break;
      cyc++;
      @(negedge clk);
    end
    req_valid = 1'b0; wr_valid = 1'b0;
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(!mem_drive, "R1 drive", mem_drive, 0);
    check(!busy && !done && !timeout_err, "R1 flags", {busy, done, timeout_err}, 0);
    check(req_ready, "R1 req_ready", req_ready, 1);
  endtask

  task automatic t_single();
    int cyc; bit d, e;
    clear_mon();
    pat[0] = 8'hA5;
    run_req(13'h100, 1, 1'b0, cyc, d, e);
    check(d && !e, "R9 single byte done", {d, e}, 2);
    check(mem_arr[10'h100] == 8'hA5, "R10 single byte stored", mem_arr[10'h100], 8'hA5);
    check(n_strobe == 1, "R10 strobe count", n_strobe, 1);
    check(v_wewidth == 0 && v_wectl == 0, "R2 strobe width/controls", v_wewidth + v_wectl, 0);
    check(v_westable == 0, "R2 address/data stable", v_westable, 0);
    check(v_rdshort == 0, "R7 read length", v_rdshort, 0);
    check(v_rdaddr == 0, "R5 poll address", v_rdaddr, 0);
    check(v_done_busy == 0 && n_busy_reads > 0, "R5 not done while busy", v_done_busy, 0);
    check(n_done == 1 && !done && !busy, "R9 one-cycle pulse", n_done, 1);
  endtask

  task automatic t_cross(input logic tmode, input logic [AW-1:0] a, input int n,
                         input int seed);
    int cyc; bit d, e; int bad = 0;
    clear_mon();
    for (int i = 0; i < n; i++) pat[i] = 8'(i * 37 + seed);
    run_req(a, n, tmode, cyc, d, e);
    for (int i = 0; i < n; i++) if (mem_arr[10'(a + AW'(i))] != pat[i]) bad++;
    check(d && !e, tmode ? "R6 cross done" : "R5 cross done", {d, e}, 2);
    check(bad == 0, "R10 burst contents", bad, 0);
    check(n_strobe == n, "R10 burst strobes", n_strobe, n);
    check(v_early == 0 && v_page == 0, "R4 page split", v_early * 256 + v_page, 0);
    check(v_contend == 0, "R3 no contention", v_contend, 0);
    check(v_done_busy == 0, tmode ? "R6 not done while busy" : "R5 not done while busy",
          v_done_busy, 0);
    check(v_rdaddr == 0 && v_rdshort == 0, "R7 poll reads", v_rdaddr + v_rdshort, 0);
    if (tmode) check(n_reads >= 4, "R6 two reads per page", n_reads, 4);
    check(n_done == 1, "R9 single done", n_done, 1);
  endtask

  task automatic t_timeout();
    int cyc; bit d, e;
    clear_mon();
    m_stuck = 1'b1;
    pat[0] = 8'h5A;
    run_req(13'h300, 1, 1'b0, cyc, d, e);
    check(e && !d, "R8 timeout flag", {d, e}, 1);
    check(cyc >= TO_C, "R8 timeout not early", cyc, TO_C);
    check(!busy && timeout_err && n_done == 0, "R8 idle after timeout", {busy, timeout_err}, 1);
    m_stuck = 1'b0;
    repeat (PROG_C + 5) @(negedge clk);
    clear_mon();
    pat[0] = 8'h33;
    run_req(13'h301, 1, 1'b1, cyc, d, e);
    check(d && !e && !timeout_err, "R8 cleared by next request", {d, e}, 2);
    check(mem_arr[10'h301] == 8'h33, "R10 after recovery", mem_arr[10'h301], 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_cross(1'b0, 13'h03C, 10, 3);
    t_cross(1'b1, 13'h07E, 3, 9);
    t_cross(1'b0, 13'h1C0, 2, 60);
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end
endmodule